// File: doc/BRIEF.md
# Instruction-Cache Line-Fill Arbiter with Prefetch Hints

This block decides which line fill goes out on the memory bus next. There are two requesters. One is a demand miss from the instruction fetch path. The other is a prefetch hint from a software cache-touch operation, which asks for a line to be loaded before it is needed. Demand always comes first. A prefetch uses the bus only when no demand miss is waiting. If a demand miss appears before the bus has accepted the prefetch, the prefetch is thrown away. Once the bus has accepted a prefetch fill, that fill runs to completion, and any demand miss waits for it.

The block has a single prefetch slot. Every fill is one whole cache line, and each bus address is the line base. The tag lookup result comes in on an input, not from this block. A force-miss control makes a hint fill its line even when the lookup reports a hit. This loads a duplicate line, which is used for testing. Each prefetch ends in one of two ways, dropped or completed, and a one-cycle pulse reports which. A second pulse reports a hint that was discarded because the slot was already full.

The demand requester raises `dmd_miss` and holds it, with `dmd_addr` unchanged, up to and including the cycle in which `dmd_fill_done` is high. It lowers `dmd_miss` in the following cycle. The bus raises `bus_ack` for one cycle, and only while `bus_req` is high. It raises `bus_done` for one cycle to end the fill it accepted.

Top module: `icache_fill_arb`

## Requirements
- R1: A hint with `hint_valid`=1 that misses (`hint_hit`=0), arriving while the slot is free, loads the slot at the next edge. From then on, while no demand miss is present and the bus is free, `bus_req`=1, `bus_low_prio`=1 and `bus_addr` is the hint address with its low log2(LINE_BYTES) bits (5 bits for 32-byte lines) cleared.
- R2: A hint that hits while `force_miss`=0 is ignored. It causes no bus request and no pulse, and the slot stays free, so a missing hint in the next cycle is accepted.
- R3: While `force_miss`=1, a hint that hits is treated as a miss and loads the slot as in R1.
- R4: While the bus is free and `dmd_miss`=1, `bus_req`=1, `bus_low_prio`=0 and `bus_addr` is the line base of `dmd_addr`, all in that same cycle, whatever the state of the slot.
- R5: If a prefetch is still waiting and not yet accepted when `dmd_miss`=1, the slot is freed at the next edge and `pf_dropped` pulses for one cycle after that edge. The dropped line is never requested again.
- R6: Once a prefetch request has been acknowledged, `bus_req` stays 0 even when `dmd_miss`=1, until `bus_done` arrives. `pf_completed` pulses in the cycle after that `bus_done`, and a waiting demand is requested in that same cycle.
- R7: A hint that needs a fill while the slot is occupied is discarded. `pf_discarded` pulses in the cycle after the hint, and the slot keeps its original line.
- R8: A request that has not been acknowledged keeps its kind and address from cycle to cycle. The one exception is a waiting prefetch that is replaced by a demand miss.
- R9: `dmd_fill_done` is high in exactly those cycles in which `bus_done`=1 ends a demand fill.
- R10: During reset and in the first cycle after it, `bus_req` and all pulse outputs are 0.
- R11: `pf_dropped` and `pf_completed` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| force_miss | input | 1 | Treat hinted lines as missing even on a hit |
| hint_valid | input | 1 | Prefetch hint strobe |
| hint_hit | input | 1 | Lookup result for the hinted line |
| hint_addr | input | ADDR_W | Byte address of the hint |
| dmd_miss | input | 1 | Demand miss pending, held until the fill completes |
| dmd_addr | input | ADDR_W | Byte address of the demand miss |
| dmd_fill_done | output | 1 | The demand fill ends in this cycle |
| bus_req | output | 1 | Line-fill request to the bus |
| bus_addr | output | ADDR_W | Line base address of the request |
| bus_low_prio | output | 1 | 1 when the request is a prefetch |
| bus_ack | input | 1 | Bus accepts the current request |
| bus_done | input | 1 | Bus finishes the accepted fill |
| pf_dropped | output | 1 | A prefetch was abandoned |
| pf_completed | output | 1 | A prefetch fill finished |
| pf_discarded | output | 1 | A hint was refused because the slot was full |

## Verification
`bus_req`, `bus_addr`, `bus_low_prio` and `dmd_fill_done` are combinational, so each is due in the same cycle as the input that causes it. The bench drives its inputs one time unit after a rising edge and samples these outputs one unit later. The slot state and the three prefetch pulses are registered, so each is due one edge after its cause. The bench samples them one unit after that edge, before it drives the next stimulus. A bench-side model advances its expected state only at those same sample points, so every comparison lines up with the cycle in which the design's result is due.

// File: rtl/icf_pkg.sv
package icf_pkg;

  // occupancy of the single prefetch slot
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,   // holds a line, bus has not accepted it
    SLOT_FLY  = 2'd2    // bus accepted it, fill under way
  } slot_st_t;

  // who owns the bus after an acknowledge
  typedef enum logic [1:0] {
    BUS_FREE = 2'd0,
    BUS_DMD  = 2'd1,
    BUS_PF   = 2'd2
  } bus_st_t;

  // a hint needs a fill when it misses, or always under force-miss
  function automatic logic hint_needs_fill(input logic hit, input logic force_miss);
    return (!hit) || force_miss;
  endfunction

endpackage

// File: rtl/icf_pf_slot.sv
module icf_pf_slot
  import icf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hint_valid,
  input  logic              hint_hit,
  input  logic              force_miss,
  input  logic [ADDR_W-1:0] hint_line,
  input  logic              dmd_miss,
  input  logic              ack_pf,
  input  logic              done_pf,
  output logic              slot_wait,
  output logic              slot_busy,
  output logic [ADDR_W-1:0] slot_line,
  output logic              pf_dropped,
  output logic              pf_completed,
  output logic              pf_discarded
);

  slot_st_t          st_q, st_d;
  logic [ADDR_W-1:0] line_q, line_d;
  logic              hint_take;
  logic              ev_drop, ev_cmpl, ev_disc;

  assign hint_take = hint_valid && hint_needs_fill(hint_hit, force_miss);

  // named events, visible to the assertions
  assign ev_drop = (st_q == SLOT_WAIT) && dmd_miss;
  assign ev_cmpl = (st_q == SLOT_FLY) && done_pf;
  assign ev_disc = hint_take && (st_q != SLOT_FREE);

  always_comb begin
    st_d   = st_q;
    line_d = line_q;
    unique case (st_q)
      SLOT_FREE: begin
        if (hint_take) begin
          st_d   = SLOT_WAIT;
          line_d = hint_line;
        end
      end
      SLOT_WAIT: begin
        if (ev_drop)     st_d = SLOT_FREE;
        else if (ack_pf) st_d = SLOT_FLY;
      end
      SLOT_FLY: begin
        if (ev_cmpl) st_d = SLOT_FREE;
      end
      default: st_d = SLOT_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SLOT_FREE;
      line_q       <= '0;
      pf_dropped   <= 1'b0;
      pf_completed <= 1'b0;
      pf_discarded <= 1'b0;
    end else begin
      st_q         <= st_d;
      line_q       <= line_d;
      pf_dropped   <= ev_drop;
      pf_completed <= ev_cmpl;
      pf_discarded <= ev_disc;
    end
  end

  assign slot_wait = (st_q == SLOT_WAIT);
  assign slot_busy = (st_q != SLOT_FREE);
  assign slot_line = line_q;

  // R5: a drop pulse always follows a cycle with a demand miss
  p_drop_follows_dmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pf_dropped |-> $past(dmd_miss));

  // R2: a hit hint without force-miss leaves a free slot free
  p_hit_hint_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SLOT_FREE && hint_valid && hint_hit && !force_miss) |=> (st_q == SLOT_FREE));

  // R7: a refused hint leaves the held line unchanged
  p_discard_keeps_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_busy && hint_valid) |=> $stable(line_q));

  // R11: the two outcomes never coincide
  p_outcome_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_dropped && pf_completed));

endmodule

// File: rtl/icf_bus_track.sv
module icf_bus_track
  import icf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic req_is_pf,
  input  logic bus_ack,
  input  logic bus_done,
  output logic bus_free,
  output logic owner_dmd,
  output logic owner_pf
);

  bus_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BUS_FREE: if (bus_req && bus_ack) st_d = req_is_pf ? BUS_PF : BUS_DMD;
      BUS_DMD,
      BUS_PF:   if (bus_done) st_d = BUS_FREE;
      default:  st_d = BUS_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BUS_FREE;
    else        st_q <= st_d;
  end

  assign bus_free  = (st_q == BUS_FREE);
  assign owner_dmd = (st_q == BUS_DMD);
  assign owner_pf  = (st_q == BUS_PF);

  // R6: an accepted prefetch keeps the bus until its done arrives
  p_pf_owns_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_pf && !bus_done) |=> owner_pf);

endmodule

// File: rtl/icf_req_mux.sv
module icf_req_mux #(
  parameter int ADDR_W = 32
) (
  input  logic              bus_free,
  input  logic              dmd_miss,
  input  logic [ADDR_W-1:0] dmd_line,
  input  logic              slot_wait,
  input  logic [ADDR_W-1:0] slot_line,
  output logic              bus_req,
  output logic              bus_low_prio,
  output logic [ADDR_W-1:0] bus_addr
);

  logic pick_pf;

  // demand first; the prefetch only when nothing else wants the bus
  assign pick_pf      = slot_wait && !dmd_miss;
  assign bus_req      = bus_free && (dmd_miss || slot_wait);
  assign bus_low_prio = pick_pf;
  assign bus_addr     = pick_pf ? slot_line : dmd_line;

endmodule

// File: rtl/icache_fill_arb.sv
module icache_fill_arb
  import icf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_miss,
  input  logic              hint_valid,
  input  logic              hint_hit,
  input  logic [ADDR_W-1:0] hint_addr,
  input  logic              dmd_miss,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              dmd_fill_done,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_low_prio,
  input  logic              bus_ack,
  input  logic              bus_done,
  output logic              pf_dropped,
  output logic              pf_completed,
  output logic              pf_discarded
);

  localparam int OFS_W = $clog2(LINE_BYTES);

  // line base: clear the byte offset inside a line
  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = {ADDR_W{1'b1}} << OFS_W;
    return a & m;
  endfunction

  logic              bus_free, owner_dmd, owner_pf;
  logic              slot_wait, slot_busy;
  logic [ADDR_W-1:0] slot_line;
  logic              ack_pf, done_pf;

  assign ack_pf        = bus_req && bus_ack && bus_low_prio;
  assign done_pf       = owner_pf && bus_done;
  assign dmd_fill_done = owner_dmd && bus_done;

  icf_pf_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .hint_valid   (hint_valid),
    .hint_hit     (hint_hit),
    .force_miss   (force_miss),
    .hint_line    (line_base(hint_addr)),
    .dmd_miss     (dmd_miss),
    .ack_pf       (ack_pf),
    .done_pf      (done_pf),
    .slot_wait    (slot_wait),
    .slot_busy    (slot_busy),
    .slot_line    (slot_line),
    .pf_dropped   (pf_dropped),
    .pf_completed (pf_completed),
    .pf_discarded (pf_discarded)
  );

  icf_bus_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .req_is_pf (bus_low_prio),
    .bus_ack   (bus_ack),
    .bus_done  (bus_done),
    .bus_free  (bus_free),
    .owner_dmd (owner_dmd),
    .owner_pf  (owner_pf)
  );

  icf_req_mux #(.ADDR_W(ADDR_W)) u_mux (
    .bus_free     (bus_free),
    .dmd_miss     (dmd_miss),
    .dmd_line     (line_base(dmd_addr)),
    .slot_wait    (slot_wait),
    .slot_line    (slot_line),
    .bus_req      (bus_req),
    .bus_low_prio (bus_low_prio),
    .bus_addr     (bus_addr)
  );

  // R6: no new request while a fill is under way
  p_no_req_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_free |-> !bus_req);

  // R8: an unanswered prefetch either repeats unchanged or yields to demand
  p_pf_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_low_prio && !bus_ack) |=>
      (bus_req && (!bus_low_prio || $stable(bus_addr))));

  // R8: an unanswered demand request stays a demand request
  p_dmd_req_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_low_prio && !bus_ack) |=> (bus_req && !bus_low_prio));

  // R1: every request address is a line base
  p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[OFS_W-1:0] == '0));

  // R9: a demand completion only while the slot is not in flight
  p_dmd_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dmd_fill_done |-> !done_pf);

endmodule

// File: tb/sim_icache_fill_arb.sv
module sim_icache_fill_arb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_miss = 1'b0;
  logic        hint_valid = 1'b0;
  logic        hint_hit = 1'b0;
  logic [31:0] hint_addr = '0;
  logic        dmd_miss = 1'b0;
  logic [31:0] dmd_addr = '0;
  logic        bus_ack = 1'b0;
  logic        bus_done = 1'b0;
  logic        dmd_fill_done, bus_req, bus_low_prio;
  logic [31:0] bus_addr;
  logic        pf_dropped, pf_completed, pf_discarded;

  always #2 clk = ~clk;   // 250 MHz

  icache_fill_arb u0 (
    .clk(clk), .rst_n(rst_n), .force_miss(force_miss),
    .hint_valid(hint_valid), .hint_hit(hint_hit), .hint_addr(hint_addr),
    .dmd_miss(dmd_miss), .dmd_addr(dmd_addr), .dmd_fill_done(dmd_fill_done),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_low_prio(bus_low_prio),
    .bus_ack(bus_ack), .bus_done(bus_done),
    .pf_dropped(pf_dropped), .pf_completed(pf_completed), .pf_discarded(pf_discarded)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench-side model: slot 0 free, 1 waiting, 2 in flight; bus 0 free, 1 demand, 2 prefetch
  int          m_slot = 0;
  int          m_bus  = 0;
  logic [31:0] m_line = '0;

  function automatic logic [31:0] base_of(input logic [31:0] a);
    return (a / 32) * 32;
  endfunction

  function automatic bit want_req();
    return (m_bus == 0) && (dmd_miss || m_slot == 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one cycle: check combinational outputs, clock, check registered pulses
  task automatic step();
    bit ereq, elp, edfd, need, edisc, edrop, ecmpl, acc;
    logic [31:0] eaddr;
    int ns, nb;
    logic [31:0] nl;
    #1;
    ereq  = want_req();
    elp   = !dmd_miss && (m_slot == 1);
    eaddr = dmd_miss ? base_of(dmd_addr) : m_line;
    edfd  = bus_done && (m_bus == 1);
    chk(bus_req === ereq, dmd_miss ? "R4 req" : "R1/R6 req", 32'(bus_req), 32'(ereq));
    if (ereq) begin
      chk(bus_low_prio === elp, dmd_miss ? "R4 prio" : "R1 prio", 32'(bus_low_prio), 32'(elp));
      chk(bus_addr === eaddr, dmd_miss ? "R4 addr" : "R8 addr", bus_addr, eaddr);
    end
    chk(dmd_fill_done === edfd, "R9 dmd_fill_done", 32'(dmd_fill_done), 32'(edfd));
    need  = hint_valid && (!hint_hit || force_miss);
    edisc = need && (m_slot != 0);
    edrop = (m_slot == 1) && dmd_miss;
    ecmpl = (m_slot == 2) && bus_done && (m_bus == 2);
    acc   = ereq && bus_ack;
    ns = m_slot; nb = m_bus; nl = m_line;
    case (m_slot)
      0: if (need) begin ns = 1; nl = base_of(hint_addr); end
      1: if (edrop) ns = 0; else if (acc && elp) ns = 2;
      default: if (ecmpl) ns = 0;
    endcase
    if (m_bus == 0) begin
      if (acc) nb = elp ? 2 : 1;
    end else if (bus_done) nb = 0;
    @(posedge clk); #1;
    chk(pf_dropped === edrop, "R5 pf_dropped", 32'(pf_dropped), 32'(edrop));
    chk(pf_completed === ecmpl, "R6 pf_completed", 32'(pf_completed), 32'(ecmpl));
    chk(pf_discarded === edisc, "R7 pf_discarded", 32'(pf_discarded), 32'(edisc));
    chk(!(pf_dropped && pf_completed), "R11 outcome exclusive", {pf_dropped, pf_completed}, 32'd0);
    m_slot = ns; m_bus = nb; m_line = nl;
  endtask

  task automatic idle_in();
    hint_valid = 0; bus_ack = 0; bus_done = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    bit dmd_rel;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1;
    chk(bus_req === 1'b0 && pf_dropped === 1'b0, "R10 during reset", {bus_req, pf_dropped}, 32'd0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(bus_req === 1'b0, "R10 req after reset", 32'(bus_req), 32'd0);
    chk({pf_dropped, pf_completed, pf_discarded} === 3'b000, "R10 pulses after reset",
        {pf_dropped, pf_completed, pf_discarded}, 32'd0);

    // R2: a hit hint is ignored, the next missing hint is accepted
    hint_valid = 1; hint_hit = 1; hint_addr = 32'h0000_1234;
    step();
    idle_in();
    #1;
    chk(bus_req === 1'b0, "R2 no request for hit", 32'(bus_req), 32'd0);
    // R1: a missing hint loads the slot; the address is taken as a line base
    hint_valid = 1; hint_hit = 0; hint_addr = 32'h0000_20A7;
    step();
    idle_in();
    #1;
    chk(bus_req && bus_low_prio && bus_addr == 32'h0000_20A0, "R1 prefetch request",
        bus_addr, 32'h0000_20A0);
    // R7: a second hint is refused; R8 address stays while unanswered
    hint_valid = 1; hint_addr = 32'h0000_9900;
    step();
    idle_in();
    step();
    chk(bus_addr === 32'h0000_20A0, "R8 held address", bus_addr, 32'h0000_20A0);
    // R5: a demand miss displaces the unanswered prefetch
    dmd_miss = 1; dmd_addr = 32'h0000_4444;
    step();
    chk(pf_dropped === 1'b1, "R5 drop pulse", 32'(pf_dropped), 32'd1);
    bus_ack = 1;
    step();
    bus_ack = 0;
    step();
    bus_done = 1;
    step();
    bus_done = 0; dmd_miss = 0;
    step();
    chk(bus_req === 1'b0, "R5 dropped line not requested", 32'(bus_req), 32'd0);

    // R3: force-miss turns a hit into a fill
    force_miss = 1; hint_valid = 1; hint_hit = 1; hint_addr = 32'h0000_7788;
    step();
    idle_in(); force_miss = 0;
    // R6: accept the prefetch, then a demand must wait
    bus_ack = 1;
    step();
    bus_ack = 0; dmd_miss = 1; dmd_addr = 32'h0000_5500;
    step();
    chk(bus_req === 1'b0, "R6 demand waits for prefetch", 32'(bus_req), 32'd0);
    bus_done = 1;
    step();
    chk(pf_completed === 1'b1, "R6 completion pulse", 32'(pf_completed), 32'd1);
    bus_done = 0;
    #1;
    chk(bus_req && !bus_low_prio && bus_addr == 32'h0000_5500, "R6 demand issued after fill",
        bus_addr, 32'h0000_5500);
    bus_ack = 1;
    step();
    bus_ack = 0; bus_done = 1;
    step();
    bus_done = 0; dmd_miss = 0;
    step();

    // constrained random traffic
    dmd_rel = 0;
    for (int i = 0; i < 4000; i++) begin
      hint_valid = ($urandom % 4) == 0;
      hint_hit   = $urandom % 2;
      hint_addr  = $urandom;
      if (($urandom % 16) == 0) force_miss = ~force_miss;
      if (dmd_rel) begin dmd_miss = 0; dmd_rel = 0; end
      else if (!dmd_miss && ($urandom % 8) == 0) begin dmd_miss = 1; dmd_addr = $urandom; end
      bus_done = (m_bus != 0) && (($urandom % 3) == 0);
      bus_ack  = want_req() && (($urandom % 2) == 0);
      if (bus_done && m_bus == 1) dmd_rel = 1;
      step();
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule